// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a finite impulse response filter that works on blocks of three samples. Samples arrive one at a time, each marked by a valid strobe. A gathering stage collects them into groups. Each group holds x(3k), x(3k+1) and x(3k+2).

When the third sample of a group arrives, a parallel core evaluates the three outputs y(3k), y(3k+1) and y(3k+2) in the same cycle. It uses the current group and a small history register. That register holds the trailing samples of the previous group. The three results are latched, then played back one per clock as a serial output stream with its own valid strobe.

The arithmetic core only does work once every three samples. Its effective processor period is therefore three sample periods, while the serial stream still runs at one sample per clock. The coefficients are signed inputs and are read at the moment each group completes.

Top module: `fir_block3`

## Requirements
- R1: While reset is asserted, and after it is released, `outValid` is low until a group completes. The history register clears to zero, so the first group is filtered as if all earlier samples were zero.
- R2: Every third accepted sample (`inValid` high at a rising clock edge) completes a group. Idle cycles between samples do not change the count.
- R3: After the clock edge that accepts a group's third sample, `outValid` is high for exactly the next three cycles. It then goes low unless another group has completed.
- R4: Within a burst, the outputs appear in the order y(3k), y(3k+1), y(3k+2).
- R5: Each output is y(n) = h0·x(n) + h1·x(n−1) + h2·x(n−2), with signed two's-complement samples and coefficients. `coefs` bits [7:0] hold h0, bits [15:8] hold h1 and bits [23:16] hold h2.
- R6: Outputs near the start of a group use samples from the previous group (x(3k−1), x(3k−2)). The result equals a sample-by-sample reference filter across group boundaries.
- R7: The value on `inSample` while `inValid` is low has no effect on any output.
- R8: `outSample` is 18 bits signed and is exact for all operand extremes, including every coefficient and every sample at −128.
- R9: Samples may arrive on every clock without gaps. The output stream then runs continuously with no lost or repeated result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks `inSample` as a new sample |
| inSample | input | 8 | Signed input sample |
| coefs | input | 24 | Packed signed coefficients h2:h1:h0 |
| outValid | output | 1 | Marks `outSample` as a filtered result |
| outSample | output | 18 | Signed filtered result |

## Verification
The checker assumes that at most one sample is accepted per clock. Under that assumption, a new group can complete no sooner than the third cycle after the previous one, so a playback burst is never overrun mid-sequence. The checker also assumes that `inValid` is the only sample qualifier, with no backpressure. The stimulus drives at most one sample per clock, both back to back and with random idle gaps carrying garbage data. It changes coefficients only between driving steps, and it always applies reset synchronously to the falling edge.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int BLOCK = 3;

  typedef struct packed {
    logic       captureEn;
    logic [1:0] laneSel;
    logic       blockReady;
    logic       emitValid;
    logic [1:0] emitSel;
  } firStrobes_t;
endpackage

// File: rtl/fir3_ctrl.sv
module fir3_ctrl
  import fir3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output firStrobes_t strobes
);
  logic [1:0] laneCnt;
  logic       emitActive;
  logic [1:0] emitIdx;
  logic       lastLane;

  assign lastLane = (laneCnt == 2'(BLOCK - 1));

  // serial-to-parallel position counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneCnt <= '0;
    end else if (inValid) begin
      laneCnt <= lastLane ? '0 : laneCnt + 2'd1;
    end
  end

  // parallel-to-serial playback sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emitActive <= 1'b0;
      emitIdx    <= '0;
    end else if (inValid && lastLane) begin
      emitActive <= 1'b1;
      emitIdx    <= '0;
    end else if (emitActive) begin
      if (emitIdx == 2'(BLOCK - 1)) begin
        emitActive <= 1'b0;
        emitIdx    <= '0;
      end else begin
        emitIdx <= emitIdx + 2'd1;
      end
    end
  end

  always_comb begin
    strobes.captureEn  = inValid && !lastLane;
    strobes.laneSel    = laneCnt;
    strobes.blockReady = inValid && lastLane;
    strobes.emitValid  = emitActive;
    strobes.emitSel    = emitIdx;
  end
endmodule

// File: rtl/fir3_datapath.sv
module fir3_datapath
  import fir3_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 3,
  parameter int OW   = DW + CW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  firStrobes_t          strobes,
  input  logic [DW-1:0]        inSample,
  input  logic [TAPS*CW-1:0]   coefs,
  output logic [OW-1:0]        outSample
);
  localparam int HIST = TAPS - 1;
  localparam int WIN  = HIST + BLOCK;

  logic signed [DW-1:0] lane  [BLOCK-1];
  logic signed [DW-1:0] hist  [HIST];
  logic signed [DW-1:0] win   [WIN];
  logic signed [CW-1:0] hCoef [TAPS];
  logic signed [OW-1:0] term  [BLOCK][TAPS];
  logic signed [OW-1:0] ySum  [BLOCK];
  logic signed [OW-1:0] yBuf  [BLOCK];

  // lanes holding the first samples of the current group
  for (genvar j = 0; j < BLOCK - 1; j++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lane[j] <= '0;
      end else if (strobes.captureEn && strobes.laneSel == 2'(j)) begin
        lane[j] <= inSample;
      end
    end
  end

  // window: oldest history first, newest (live) sample last
  for (genvar i = 0; i < HIST; i++) begin : g_winHist
    assign win[i] = hist[i];
  end
  for (genvar j = 0; j < BLOCK - 1; j++) begin : g_winLane
    assign win[HIST + j] = lane[j];
  end
  assign win[WIN-1] = inSample;

  for (genvar i = 0; i < TAPS; i++) begin : g_coef
    assign hCoef[i] = coefs[i*CW +: CW];
  end

  // products for every output lane and tap
  for (genvar j = 0; j < BLOCK; j++) begin : g_out
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign term[j][i] = OW'(win[HIST + j - i]) * OW'(hCoef[i]);
    end
  end

  always_comb begin
    for (int j = 0; j < BLOCK; j++) begin
      ySum[j] = '0;
      for (int i = 0; i < TAPS; i++) begin
        ySum[j] = ySum[j] + term[j][i];
      end
    end
  end

  // history keeps the newest HIST samples of the finished group
  for (genvar i = 0; i < HIST; i++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hist[i] <= '0;
      end else if (strobes.blockReady) begin
        hist[i] <= win[i + BLOCK];
      end
    end
  end

  for (genvar j = 0; j < BLOCK; j++) begin : g_ybuf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        yBuf[j] <= '0;
      end else if (strobes.blockReady) begin
        yBuf[j] <= ySum[j];
      end
    end
  end

  assign outSample = yBuf[strobes.emitSel];
endmodule

// File: rtl/fir_block3.sv
module fir_block3
  import fir3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 3,
  parameter int OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [DATA_W-1:0]        inSample,
  input  logic [TAPS*COEF_W-1:0]   coefs,
  output logic                     outValid,
  output logic [OUT_W-1:0]         outSample
);
  firStrobes_t strobes;

  fir3_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes)
  );

  fir3_datapath #(
    .DW   (DATA_W),
    .CW   (COEF_W),
    .TAPS (TAPS),
    .OW   (OUT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inSample  (inSample),
    .coefs     (coefs),
    .outSample (outSample)
  );

  assign outValid = strobes.emitValid;
endmodule

// File: rtl/fir3_checker.sv
module fir3_checker
  import fir3_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        outValid,
  input firStrobes_t strobes
);
  logic [1:0] chkCnt;
  logic       seenBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt    <= '0;
      seenBlock <= 1'b0;
    end else begin
      if (inValid) chkCnt <= (chkCnt == 2'd2) ? 2'd0 : chkCnt + 2'd1;
      if (strobes.blockReady) seenBlock <= 1'b1;
    end
  end

  assert_no_early_output_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> seenBlock);

  assert_third_sample_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && chkCnt == 2'd2) |-> strobes.blockReady);

  assert_ready_only_third_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blockReady |-> (inValid && chkCnt == 2'd2));

  assert_burst_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blockReady |=> (outValid && strobes.emitSel == 2'd0));

  assert_burst_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && strobes.emitSel == 2'd2 && !strobes.blockReady) |=> !outValid);

  assert_emit_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && strobes.emitSel != 2'd2)
      |=> (outValid && strobes.emitSel == $past(strobes.emitSel) + 2'd1));
endmodule

bind fir_block3 fir3_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .strobes  (strobes)
);

// File: tb/fir_block3_tb.sv
`timescale 1ns/1ps
module fir_block3_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [7:0]  inSample;
  logic [23:0] coefs;
  logic        outValid;
  logic [17:0] outSample;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycCnt   = 0;
  string phaseTag = "R1";

  // reference model state
  int blk [3];
  int pos = 0;
  int mh1 = 0;
  int mh2 = 0;
  int emitLeft = 0;
  int expQ [1024];
  int wrIdx = 0;
  int rdIdx = 0;

  always #5 clk = ~clk;

  fir_block3 u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSample  (inSample),
    .coefs     (coefs),
    .outValid  (outValid),
    .outSample (outSample)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int sx8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  // monitor: sample inputs at the edge, compare outputs just after it
  always @(posedge clk) begin
    logic        sV;
    logic        sR;
    int          sX;
    logic [23:0] sC;
    bit          done;
    int          w [5];
    int          h [3];
    int          acc;
    int          got;
    sV = inValid; sR = rstN; sX = sx8(inSample); sC = coefs;
    #1;
    if (!sR) begin
      pos = 0; mh1 = 0; mh2 = 0; emitLeft = 0; rdIdx = wrIdx;
      check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    end else begin
      done = 0;
      if (sV) begin
        blk[pos] = sX;
        pos++;
        if (pos == 3) begin
          h[0] = sx8(sC[7:0]); h[1] = sx8(sC[15:8]); h[2] = sx8(sC[23:16]);
          w[0] = mh2; w[1] = mh1; w[2] = blk[0]; w[3] = blk[1]; w[4] = blk[2];
          for (int j = 0; j < 3; j++) begin
            acc = 0;
            for (int i = 0; i < 3; i++) acc += h[i] * w[2 + j - i];
            expQ[wrIdx % 1024] = acc;
            wrIdx++;
          end
          mh2 = blk[1]; mh1 = blk[2];
          pos = 0; done = 1;
        end
      end
      if (done) emitLeft = 3;
      else if (emitLeft > 0) emitLeft--;
      check(outValid == (emitLeft > 0), "R2 R3 outValid timing", int'(outValid),
            int'(emitLeft > 0));
      if (outValid && emitLeft > 0 && rdIdx < wrIdx) begin
        got = int'($signed(outSample));
        check(got == expQ[rdIdx % 1024], {phaseTag, " R4 R5 R6 value"}, got,
              expQ[rdIdx % 1024]);
        rdIdx++;
      end
    end
  end

  task automatic setCoefs(input int h0, input int h1, input int h2);
    @(negedge clk);
    coefs = {8'(h2), 8'(h1), 8'(h0)};
  endtask

  task automatic sendSample(input int x, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      inValid  = 1'b0;
      inSample = 8'($urandom_range(0, 255));
    end
    @(negedge clk);
    inValid  = 1'b1;
    inSample = 8'(x);
  endtask

  task automatic idle(input int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      inValid  = 1'b0;
      inSample = 8'($urandom_range(0, 255));
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0;
    idle(4);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt == 150000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cycCnt, 0);
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inSample = '0; coefs = '0;
    applyReset();

    // R1: first group sees zero history
    phaseTag = "R1";
    setCoefs(1, 2, 3);
    for (int n = 1; n <= 6; n++) sendSample(10 * n, 0);
    idle(6);

    // R5: impulse-like and mixed coefficient sets
    phaseTag = "R5";
    for (int c = 0; c < 6; c++) begin
      case (c)
        0: setCoefs(1, 0, 0);
        1: setCoefs(0, 1, 0);
        2: setCoefs(0, 0, 1);
        3: setCoefs(3, -2, 5);
        4: setCoefs(-7, 11, -13);
        default: setCoefs(127, -1, 64);
      endcase
      for (int n = 0; n < 12; n++) sendSample($urandom_range(0, 255) - 128, 0);
      idle(5);
    end

    // R8: operand extremes
    phaseTag = "R8";
    setCoefs(-128, -128, -128);
    for (int n = 0; n < 9; n++) sendSample(-128, 0);
    for (int n = 0; n < 6; n++) sendSample(127, 0);
    setCoefs(127, 127, 127);
    for (int n = 0; n < 9; n++) sendSample(((n % 2) == 0) ? -128 : 127, 0);
    idle(6);

    // R7: gaps carrying garbage data
    phaseTag = "R7 R2";
    setCoefs(5, -9, 17);
    for (int n = 0; n < 36; n++) sendSample($urandom_range(0, 255) - 128,
                                            $urandom_range(0, 3));
    idle(6);

    // R9: continuous stream
    phaseTag = "R9";
    setCoefs($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
             $urandom_range(0, 255) - 128);
    for (int n = 0; n < 90; n++) sendSample($urandom_range(0, 255) - 128, 0);
    idle(6);

    // R1: reset in the middle of a group clears history and position
    phaseTag = "R1";
    sendSample(99, 0);
    sendSample(-77, 0);
    applyReset();
    setCoefs(2, 3, 4);
    for (int n = 0; n < 6; n++) sendSample(n + 1, 0);
    idle(6);

    check(rdIdx == wrIdx, "R3 all results emitted", rdIdx, wrIdx);
    finishRun();
  end
endmodule